// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block changes the multiplier of a PLL by driving a fixed series of accesses over a simple register write/read port. A client presents a packed multiplier word, the requested output rate and the current input rate, and pulses a request. The sequencer first refuses any request that asks for a higher output rate than the input rate. Otherwise it powers the PLL down with bypass, both direct paths and the output clock switched off. It then loads the multiplier, sets both dividers to one, and powers the PLL up again. After that it polls the lock flag with a timed pause in front of every poll.

When lock is seen within the allowed number of polls, the sequencer turns the PLL output clock on and reports success. When lock never appears, it reports a lock failure and leaves the output clock off. The pause length is derived from the clock frequency parameter and a microsecond parameter. The register block, the PLL and the multiplier encoding all sit outside this block.

Top module: `pllReprogSeq`

## Requirements
- R1: After reset, busy, done, all three outcome flags and both register strobes are low.
- R2: A request taken while idle raises busy in the next cycle. busy stays high up to and including the done cycle. A request that arrives while busy is ignored and does not change the running sequence.
- R3: When the requested output rate is strictly greater than the input rate, the request ends with done and rateErr one cycle after acceptance, with no register access. An output rate equal to the input rate is accepted.
- R4: An accepted sequence first reads control at BASE_ADDR+4 and then writes control with bit 0 (power-down) set. In that write bit 1 (bypass), bit 2 (direct input), bit 3 (direct output) and bit 4 (clock enable) are cleared and bits 31..5 are kept from the value read. Read data is taken the cycle after the read strobe.
- R5: Next the multiplier word is written unchanged to BASE_ADDR+8, followed by 32'h00302062 (both dividers equal to one) written to BASE_ADDR+12.
- R6: Next control is written with bits 4..0 all cleared and bits 31..5 kept, which powers the PLL up.
- R7: Each status read at BASE_ADDR+0 comes at least WAIT_CYC = CLK_HZ/1e6*WAIT_US cycles after the power-up write or the previous status read.
- R8: If status reads show lock on attempt k (k ≤ POLL_TRIES = 4), exactly k status reads happen. Control is then written with bit 4 set, bits 3..0 cleared and bits 31..5 kept, and the sequence ends with done and ok.
- R9: If POLL_TRIES status reads all lack lock, the sequence ends with done and lockErr after exactly POLL_TRIES reads, with no write that sets clock enable.
- R10: done lasts exactly one cycle and is followed by idle. Exactly one of ok, rateErr and lockErr is high with done, and none is high otherwise.
- R11: Only status bit 0 signals lock. A status word with every other bit set counts as not locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request pulse |
| reqMult | input | DATA_W | Packed multiplier word to load |
| reqOutRate | input | RATE_W | Requested output rate |
| reqInRate | input | RATE_W | Current input rate |
| regWrEn | output | 1 | Register write strobe |
| regRdEn | output | 1 | Register read strobe |
| regAddr | output | ADDR_W | Register address |
| regWrData | output | DATA_W | Register write data |
| regRdData | input | DATA_W | Read data, valid the cycle after regRdEn |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Success, valid with done |
| rateErr | output | 1 | Rate refusal, valid with done |
| lockErr | output | 1 | Lock failure, valid with done |

## Verification
The bench goes after the lock count edges: lock on the first poll, lock on the last allowed poll, and no lock at all. A retry counter that is off by one would either poll a fifth time or give up after three. Status words with every upper bit set and lock clear catch a design that tests the whole word instead of bit 0. Preset control values with ones in the upper bits and in bits 4..0 expose a read-modify-write that drops kept bits or forgets to clear one. A rate equal to the input rate and a second request sent during polling catch a wrong compare and a sequencer that restarts while busy.

// File: rtl/pllSeqPkg.sv
package pllSeqPkg;

  localparam int BIT_PD    = 0;
  localparam int BIT_CLKEN = 4;
  localparam int BIT_LOCK  = 0;

  localparam logic [31:0] CTRL_CLR_MASK = 32'h0000_001F;
  localparam logic [31:0] DIV_UNITY     = 32'h0030_2062;

  localparam int OFF_STAT = 0;
  localparam int OFF_CTRL = 4;
  localparam int OFF_MULT = 8;
  localparam int OFF_DIV  = 12;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_RD_CTRL,
    OP_WR_PD,
    OP_WR_MULT,
    OP_WR_DIV,
    OP_WR_PU,
    OP_RD_STAT,
    OP_WR_EN
  } regOpE;

  typedef struct packed {
    logic  latchReq;
    regOpE op;
    logic  captureCtrl;
    logic  loadDelay;
    logic  clearTries;
    logic  incTry;
  } seqStrobeT;

  typedef enum logic [1:0] {
    RES_OK,
    RES_RATE,
    RES_LOCK
  } resultE;

endpackage

// File: rtl/pllSeqData.sv
module pllSeqData
  import pllSeqPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int RATE_W = 32,
  parameter int WAIT_CYC = 1000,
  parameter int POLL_TRIES = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobeT         strobe,
  input  logic [DATA_W-1:0] reqMult,
  input  logic [RATE_W-1:0] reqOutRate,
  input  logic [RATE_W-1:0] reqInRate,
  input  logic [DATA_W-1:0] regRdData,
  output logic              regWrEn,
  output logic              regRdEn,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic              rateBad,
  output logic              delayDone,
  output logic              lockSeen,
  output logic              lastTry
);

  localparam int CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
  localparam int TRY_W = (POLL_TRIES > 1) ? $clog2(POLL_TRIES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WAIT_CYC - 1);
  localparam logic [TRY_W-1:0] TRY_LAST = TRY_W'(POLL_TRIES - 1);
  localparam logic [DATA_W-1:0] CLR_MASK = DATA_W'(CTRL_CLR_MASK);

  logic [DATA_W-1:0] multQ;
  logic [DATA_W-1:0] ctrlShadowQ;
  logic [DATA_W-1:0] ctrlClean;
  logic [CNT_W-1:0]  delayCntQ;
  logic [TRY_W-1:0]  triesQ;

  assign rateBad   = reqOutRate > reqInRate;
  assign delayDone = delayCntQ == '0;
  assign lockSeen  = regRdData[BIT_LOCK];
  assign lastTry   = triesQ == TRY_LAST;
  assign ctrlClean = ctrlShadowQ & ~CLR_MASK;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      multQ       <= '0;
      ctrlShadowQ <= '0;
    end else begin
      if (strobe.latchReq)    multQ       <= reqMult;
      if (strobe.captureCtrl) ctrlShadowQ <= regRdData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      delayCntQ <= '0;
    end else if (strobe.loadDelay) begin
      delayCntQ <= CNT_LOAD;
    end else if (!delayDone) begin
      delayCntQ <= delayCntQ - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      triesQ <= '0;
    end else if (strobe.clearTries) begin
      triesQ <= '0;
    end else if (strobe.incTry) begin
      triesQ <= triesQ + 1'b1;
    end
  end

  always_comb begin
    regWrEn   = 1'b0;
    regRdEn   = 1'b0;
    regAddr   = BASE_ADDR;
    regWrData = '0;
    case (strobe.op)
      OP_RD_CTRL: begin
        regRdEn = 1'b1;
        regAddr = BASE_ADDR + ADDR_W'(OFF_CTRL);
      end
      OP_WR_PD: begin
        regWrEn   = 1'b1;
        regAddr   = BASE_ADDR + ADDR_W'(OFF_CTRL);
        regWrData = ctrlClean | (DATA_W'(1) << BIT_PD);
      end
      OP_WR_MULT: begin
        regWrEn   = 1'b1;
        regAddr   = BASE_ADDR + ADDR_W'(OFF_MULT);
        regWrData = multQ;
      end
      OP_WR_DIV: begin
        regWrEn   = 1'b1;
        regAddr   = BASE_ADDR + ADDR_W'(OFF_DIV);
        regWrData = DATA_W'(DIV_UNITY);
      end
      OP_WR_PU: begin
        regWrEn   = 1'b1;
        regAddr   = BASE_ADDR + ADDR_W'(OFF_CTRL);
        regWrData = ctrlClean;
      end
      OP_RD_STAT: begin
        regRdEn = 1'b1;
        regAddr = BASE_ADDR + ADDR_W'(OFF_STAT);
      end
      OP_WR_EN: begin
        regWrEn   = 1'b1;
        regAddr   = BASE_ADDR + ADDR_W'(OFF_CTRL);
        regWrData = ctrlClean | (DATA_W'(1) << BIT_CLKEN);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/pllSeqCtrl.sv
module pllSeqCtrl
  import pllSeqPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      rateBad,
  input  logic      delayDone,
  input  logic      lockSeen,
  input  logic      lastTry,
  output seqStrobeT strobe,
  output logic      busy,
  output logic      done,
  output logic      ok,
  output logic      rateErr,
  output logic      lockErr
);

  typedef enum logic [3:0] {
    S_IDLE,
    S_RD_CTRL,
    S_CAP_CTRL,
    S_WR_PD,
    S_WR_MULT,
    S_WR_DIV,
    S_WR_PU,
    S_DELAY,
    S_RD_STAT,
    S_CHK_STAT,
    S_WR_EN,
    S_DONE
  } stateE;

  stateE  stateQ, stateD;
  resultE resultQ, resultD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= S_IDLE;
      resultQ <= RES_OK;
    end else begin
      stateQ  <= stateD;
      resultQ <= resultD;
    end
  end

  always_comb begin
    stateD  = stateQ;
    resultD = resultQ;
    strobe  = '{latchReq: 1'b0, op: OP_NONE, captureCtrl: 1'b0,
                loadDelay: 1'b0, clearTries: 1'b0, incTry: 1'b0};
    case (stateQ)
      S_IDLE: begin
        if (reqValid) begin
          strobe.latchReq = 1'b1;
          if (rateBad) begin
            resultD = RES_RATE;
            stateD  = S_DONE;
          end else begin
            stateD = S_RD_CTRL;
          end
        end
      end
      S_RD_CTRL: begin
        strobe.op = OP_RD_CTRL;
        stateD    = S_CAP_CTRL;
      end
      S_CAP_CTRL: begin
        strobe.captureCtrl = 1'b1;
        stateD             = S_WR_PD;
      end
      S_WR_PD: begin
        strobe.op = OP_WR_PD;
        stateD    = S_WR_MULT;
      end
      S_WR_MULT: begin
        strobe.op = OP_WR_MULT;
        stateD    = S_WR_DIV;
      end
      S_WR_DIV: begin
        strobe.op = OP_WR_DIV;
        stateD    = S_WR_PU;
      end
      S_WR_PU: begin
        strobe.op         = OP_WR_PU;
        strobe.loadDelay  = 1'b1;
        strobe.clearTries = 1'b1;
        stateD            = S_DELAY;
      end
      S_DELAY: begin
        if (delayDone) stateD = S_RD_STAT;
      end
      S_RD_STAT: begin
        strobe.op = OP_RD_STAT;
        stateD    = S_CHK_STAT;
      end
      S_CHK_STAT: begin
        if (lockSeen) begin
          stateD = S_WR_EN;
        end else if (lastTry) begin
          resultD = RES_LOCK;
          stateD  = S_DONE;
        end else begin
          strobe.incTry    = 1'b1;
          strobe.loadDelay = 1'b1;
          stateD           = S_DELAY;
        end
      end
      S_WR_EN: begin
        strobe.op = OP_WR_EN;
        resultD   = RES_OK;
        stateD    = S_DONE;
      end
      S_DONE: begin
        stateD = S_IDLE;
      end
      default: stateD = S_IDLE;
    endcase
  end

  assign busy    = stateQ != S_IDLE;
  assign done    = stateQ == S_DONE;
  assign ok      = done && (resultQ == RES_OK);
  assign rateErr = done && (resultQ == RES_RATE);
  assign lockErr = done && (resultQ == RES_LOCK);

endmodule

// File: rtl/pllReprogSeq.sv
module pllReprogSeq
  import pllSeqPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int RATE_W = 32,
  parameter int CLK_HZ = 100_000_000,
  parameter int WAIT_US = 10,
  parameter int POLL_TRIES = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [DATA_W-1:0] reqMult,
  input  logic [RATE_W-1:0] reqOutRate,
  input  logic [RATE_W-1:0] reqInRate,
  output logic              regWrEn,
  output logic              regRdEn,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] regRdData,
  output logic              busy,
  output logic              done,
  output logic              ok,
  output logic              rateErr,
  output logic              lockErr
);

  localparam int CYC_PER_US = CLK_HZ / 1_000_000;
  localparam int WAIT_RAW   = CYC_PER_US * WAIT_US;
  localparam int WAIT_CYC   = (WAIT_RAW > 0) ? WAIT_RAW : 1;

  seqStrobeT strobe;
  logic      rateBad;
  logic      delayDone;
  logic      lockSeen;
  logic      lastTry;

  pllSeqCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .rateBad  (rateBad),
    .delayDone(delayDone),
    .lockSeen (lockSeen),
    .lastTry  (lastTry),
    .strobe   (strobe),
    .busy     (busy),
    .done     (done),
    .ok       (ok),
    .rateErr  (rateErr),
    .lockErr  (lockErr)
  );

  pllSeqData #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .RATE_W    (RATE_W),
    .WAIT_CYC  (WAIT_CYC),
    .POLL_TRIES(POLL_TRIES),
    .BASE_ADDR (BASE_ADDR)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqMult   (reqMult),
    .reqOutRate(reqOutRate),
    .reqInRate (reqInRate),
    .regRdData (regRdData),
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .rateBad   (rateBad),
    .delayDone (delayDone),
    .lockSeen  (lockSeen),
    .lastTry   (lastTry)
  );

endmodule

// File: rtl/pllSeqChecker.sv
module pllSeqChecker #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int WAIT_CYC = 1000,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              busy,
  input logic              done,
  input logic              ok,
  input logic              rateErr,
  input logic              lockErr,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWrData
);

  localparam logic [ADDR_W-1:0] A_STAT = BASE_ADDR;
  localparam logic [ADDR_W-1:0] A_CTRL = BASE_ADDR + ADDR_W'(4);

  logic [31:0] gapQ;
  logic        puWrite;
  logic        statRead;

  assign puWrite  = regWrEn && (regAddr == A_CTRL) && (regWrData[4:0] == 5'b0);
  assign statRead = regRdEn && (regAddr == A_STAT);

  always_ff @(posedge clk) begin
    if (!rstN) gapQ <= '0;
    else if (puWrite || statRead) gapQ <= 32'd1;
    else if (gapQ != 32'hFFFF_FFFF) gapQ <= gapQ + 1;
  end

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  assert_done_flags_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $onehot({ok, rateErr, lockErr}));

  assert_flags_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ({ok, rateErr, lockErr} == 3'b000));

  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy) |=> busy);

  assert_idle_no_access_R3: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!regWrEn && !regRdEn));

  assert_port_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regRdEn));

  assert_poll_gap_R7: assert property (@(posedge clk) disable iff (!rstN)
    statRead |-> (gapQ >= 32'(WAIT_CYC)));

  assert_enable_clean_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && (regAddr == A_CTRL) && regWrData[4])
      |-> ((regWrData & DATA_W'(32'h1F)) == DATA_W'(32'h10)));

endmodule

bind pllReprogSeq pllSeqChecker #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .WAIT_CYC (WAIT_CYC),
  .BASE_ADDR(BASE_ADDR)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .busy     (busy),
  .done     (done),
  .ok       (ok),
  .rateErr  (rateErr),
  .lockErr  (lockErr),
  .regWrEn  (regWrEn),
  .regRdEn  (regRdEn),
  .regAddr  (regAddr),
  .regWrData(regWrData)
);

// File: tb/tb_pllReprogSeq.sv
`timescale 1ns/1ps
module tb_pllReprogSeq;

  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int RATE_W = 32;
  localparam int WAIT_CYC = 1000;
  localparam int TRIES = 4;
  localparam logic [ADDR_W-1:0] BASE = 12'h1C0;
  localparam logic [ADDR_W-1:0] A_STAT = BASE;
  localparam logic [ADDR_W-1:0] A_CTRL = BASE + 12'd4;
  localparam logic [ADDR_W-1:0] A_MULT = BASE + 12'd8;
  localparam logic [ADDR_W-1:0] A_DIV  = BASE + 12'd12;

  typedef struct packed {
    logic [31:0] outRate;
    logic [31:0] inRate;
    logic [31:0] mult;
    logic [31:0] initCtrl;
    logic [2:0]  lockAt;
    logic [1:0]  kind;
  } vecT;

  localparam int NVEC = 7;
  localparam vecT VECS [NVEC] = '{
    '{32'd48,  32'd96,  32'h0001_2345, 32'h0000_0000, 3'd1, 2'd0},
    '{32'd480, 32'd480, 32'h00A3_F00D, 32'h0000_001F, 3'd2, 2'd0},
    '{32'd10,  32'd12,  32'h0000_0003, 32'hABCD_EF1E, 3'd4, 2'd0},
    '{32'd100, 32'd50,  32'h0000_1111, 32'h0000_0000, 3'd1, 2'd1},
    '{32'd5,   32'd50,  32'h0000_0077, 32'h0300_0010, 3'd0, 2'd2},
    '{32'd1,   32'd2,   32'h0000_0055, 32'h0000_0F0A, 3'd3, 2'd0},
    '{32'hFFFF_FFFF, 32'hFFFF_FFFE, 32'h0000_0001, 32'h0, 3'd1, 2'd1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [DATA_W-1:0] reqMult = '0;
  logic [RATE_W-1:0] reqOutRate = '0;
  logic [RATE_W-1:0] reqInRate = '0;
  logic regWrEn, regRdEn;
  logic [ADDR_W-1:0] regAddr;
  logic [DATA_W-1:0] regWrData;
  logic [DATA_W-1:0] regRdData = '0;
  logic busy, done, ok, rateErr, lockErr;

  always #5 clk = ~clk;

  pllReprogSeq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RATE_W(RATE_W),
    .CLK_HZ(100_000_000), .WAIT_US(10), .POLL_TRIES(TRIES), .BASE_ADDR(BASE)
  ) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqMult(reqMult),
    .reqOutRate(reqOutRate), .reqInRate(reqInRate),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .busy(busy), .done(done), .ok(ok), .rateErr(rateErr), .lockErr(lockErr)
  );

  // register environment model and access log
  logic [31:0] ctrlMem = '0;
  logic        presetCtrl = 1'b0;
  logic [31:0] presetVal = '0;
  logic        clearLog = 1'b0;
  int          lockAt = 0;
  int          statReads = 0;
  int          cycleCnt = 0;
  int          logN = 0;
  logic        logWr [64];
  logic [ADDR_W-1:0] logAddr [64];
  logic [31:0] logData [64];
  int          logCyc [64];

  always @(posedge clk) begin
    cycleCnt <= cycleCnt + 1;
    if (presetCtrl) ctrlMem <= presetVal;
    if (clearLog) begin
      logN <= 0;
      statReads <= 0;
    end else if ((regWrEn || regRdEn) && logN < 64) begin
      logWr[logN]   <= regWrEn;
      logAddr[logN] <= regAddr;
      logData[logN] <= regWrData;
      logCyc[logN]  <= cycleCnt;
      logN <= logN + 1;
      if (regWrEn && regAddr == A_CTRL) ctrlMem <= regWrData;
      if (regRdEn) begin
        if (regAddr == A_STAT) begin
          regRdData <= (lockAt != 0 && statReads + 1 >= lockAt) ? 32'h0000_0001 : 32'hFFFF_FFFE;
          statReads <= statReads + 1;
        end else if (regAddr == A_CTRL) begin
          regRdData <= ctrlMem;
        end else begin
          regRdData <= '0;
        end
      end
    end
  end

  int checks = 0;
  int errors = 0;

  task automatic check(input logic cond, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic prepare(input logic [31:0] initC, input int lk);
    @(negedge clk);
    presetVal = initC; presetCtrl = 1'b1; clearLog = 1'b1; lockAt = lk;
    @(negedge clk);
    presetCtrl = 1'b0; clearLog = 1'b0;
  endtask

  task automatic waitDone(output logic [2:0] flags, output logic timedOut);
    timedOut = 1'b1;
    flags = '0;
    for (int i = 0; i < 20000; i++) begin
      if (done) begin
        flags = {ok, rateErr, lockErr};
        timedOut = 1'b0;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic checkTrace(input vecT v);
    logic [31:0] clean;
    int expN;
    int k;
    clean = v.initCtrl & ~32'h1F;
    k = (v.lockAt == 0) ? TRIES : int'(v.lockAt);
    if (v.kind == 2'd1) begin
      check(logN == 0, "R3 no access on rate refusal", 64'(logN), 64'd0);
      return;
    end
    expN = 5 + k + ((v.kind == 2'd0) ? 1 : 0);
    check(logN == expN, (v.kind == 2'd0) ? "R8 access count" : "R9 access count", 64'(logN), 64'(expN));
    if (logN < expN) return;
    check(!logWr[0] && logAddr[0] == A_CTRL, "R4 first access reads control", 64'(logAddr[0]), 64'(A_CTRL));
    check(logWr[1] && logAddr[1] == A_CTRL && logData[1] == (clean | 32'h1),
          "R4 power-down write", 64'(logData[1]), 64'(clean | 32'h1));
    check(logWr[2] && logAddr[2] == A_MULT && logData[2] == v.mult,
          "R5 multiplier write", 64'(logData[2]), 64'(v.mult));
    check(logWr[3] && logAddr[3] == A_DIV && logData[3] == 32'h0030_2062,
          "R5 divider write", 64'(logData[3]), 64'h0030_2062);
    check(logWr[4] && logAddr[4] == A_CTRL && logData[4] == clean,
          "R6 power-up write", 64'(logData[4]), 64'(clean));
    for (int i = 0; i < k; i++) begin
      check(!logWr[5+i] && logAddr[5+i] == A_STAT, "R7 status read address", 64'(logAddr[5+i]), 64'(A_STAT));
      check(logCyc[5+i] - logCyc[4+i] >= WAIT_CYC, "R7 poll spacing",
            64'(logCyc[5+i] - logCyc[4+i]), 64'(WAIT_CYC));
    end
    if (v.kind == 2'd0)
      check(logWr[5+k] && logAddr[5+k] == A_CTRL && logData[5+k] == (clean | 32'h10),
            "R8 clock enable write", 64'(logData[5+k]), 64'(clean | 32'h10));
    else
      check(ctrlMem[4] == 1'b0, "R9 clock enable left clear", 64'(ctrlMem), 64'(clean));
  endtask

  task automatic runVec(input vecT v, input logic intrude);
    logic [2:0] flags;
    logic [2:0] expFlags;
    logic to;
    prepare(v.initCtrl, int'(v.lockAt));
    reqMult = v.mult; reqOutRate = v.outRate; reqInRate = v.inRate; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check(busy == 1'b1, "R2 busy after accept", 64'(busy), 64'd1);
    if (intrude) begin
      repeat (20) @(negedge clk);
      reqMult = 32'hDEAD_BEEF; reqOutRate = 32'd9; reqInRate = 32'd1; reqValid = 1'b1;
      @(negedge clk);
      reqValid = 1'b0;
      check(busy == 1'b1 && done == 1'b0, "R2 intruding request ignored", 64'({busy, done}), 64'b10);
    end
    waitDone(flags, to);
    check(!to, "R10 done within bound", 64'(to), 64'd0);
    expFlags = (v.kind == 2'd0) ? 3'b100 : (v.kind == 2'd1) ? 3'b010 : 3'b001;
    check(flags == expFlags, (v.kind == 2'd1) ? "R3 outcome flags" : "R10 outcome flags",
          64'(flags), 64'(expFlags));
    check(busy == 1'b1, "R2 busy through done cycle", 64'(busy), 64'd1);
    @(negedge clk);
    check(!done && !busy && !ok && !rateErr && !lockErr, "R10 single done then idle",
          64'({done, busy, ok, rateErr, lockErr}), 64'd0);
    checkTrace(v);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !ok && !rateErr && !lockErr && !regWrEn && !regRdEn,
          "R1 reset state", 64'({busy, done, ok, rateErr, lockErr, regWrEn, regRdEn}), 64'd0);
    // table walk; R11 exercised by not-locked status words 0xFFFFFFFE
    for (int i = 0; i < NVEC; i++) runVec(VECS[i], 1'b0);
    // directed: request during polling must not disturb the sequence (R2)
    runVec(VECS[1], 1'b1);
    // directed: lock on the last allowed poll after all-ones junk status (R11)
    runVec('{32'd3, 32'd4, 32'h0000_0ABC, 32'hFFFF_FFE0, 3'd4, 2'd0}, 1'b0);
    repeat (5) @(negedge clk);
    check(!busy && !done, "R10 stays idle", 64'({busy, done}), 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule